// File: doc/BRIEF.md
# Mask Register Right Shift Unit

This block performs an immediate logical right shift on a 64-bit mask register value. The operand width is one of 8, 16, 32 or 64 bits. It is picked at run time from an opcode byte and a single width bit. Only the low width bits of the source take part in the shift. Every destination bit above the operand width comes out as zero.

The shift count is the whole 8-bit immediate and is not reduced to the operand width. Any count beyond the width minus one clears the entire result. The block also checks the encoding it is given. A register-form ModRM byte and one of the two supported opcode bytes are required, and any other encoding raises an illegal-encoding pulse. In that case the destination output keeps its previous value.

Results are registered with a latency of one cycle. Along with the result, the unit passes out the destination and source register indices, taken from the ModRM byte, so that a surrounding pipeline can write the result back.

Top module: `mask_rshift_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid`, `bad_enc`, `dst_mask`, `dst_idx` and `src_idx` are all cleared to zero after that edge.
- R2: The width index is {opcode bit 0, `w_bit`}. Opcode 0x30 selects 8 bits when `w_bit` is 0 and 16 bits when it is 1. Opcode 0x31 selects 32 bits when `w_bit` is 0 and 64 bits when it is 1. The result is the low-width source bits shifted right by `imm_count`.
- R3: The full 8-bit `imm_count` is used. When it exceeds the operand width minus one (7, 15, 31 or 63), `dst_mask` becomes all zero.
- R4: Destination bits at and above the operand width are always zero for an accepted input.
- R5: A count of zero yields the source masked to the operand width.
- R6: A valid input whose ModRM bits 7:6 are not 2'b11 is illegal. `bad_enc` is high in the next cycle, `out_valid` stays low, and `dst_mask`, `dst_idx` and `src_idx` hold their values.
- R7: A valid input with any opcode byte other than 0x30 or 0x31 is handled as illegal, in the same way as R6.
- R8: `out_valid` is high for exactly the one cycle after an accepted valid input. When `in_valid` is low, the next cycle has `out_valid` and `bad_enc` low and all outputs unchanged.
- R9: With an accepted result, `dst_idx` carries ModRM bits 5:3 and `src_idx` carries ModRM bits 2:0 of that input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input operation strobe |
| opcode | input | 8 | Opcode byte (0x30 or 0x31 legal) |
| w_bit | input | 1 | Width-select bit |
| modrm | input | 8 | ModRM byte: mod [7:6], reg [5:3], r/m [2:0] |
| imm_count | input | 8 | Immediate shift count |
| src_mask | input | 64 | Source mask value |
| out_valid | output | 1 | Result valid, one cycle after an accepted input |
| dst_mask | output | 64 | Registered shifted result |
| dst_idx | output | 3 | Destination register index of the result |
| src_idx | output | 3 | Source register index of the result |
| bad_enc | output | 1 | Illegal-encoding pulse |

## Verification
Every internal path ends in one register stage. A fault in width decode, range check or masking therefore shows up as a wrong `dst_mask` in the very next cycle after the offending input. A fault in legality decode appears in that same cycle as a stray `bad_enc`, or as a missing `out_valid`, or as a destination that changes when it should hold. The stimulus covers every width with counts of zero, width minus one, width, and 255, together with random sources. Illegal inputs are placed right after legal ones, so that any overwrite of held state becomes visible.

// File: rtl/mask_rshift_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the mask right shift unit.
// Assumes the width index is formed as {opcode[0], w_bit}.
package mask_rshift_pkg;

    localparam int unsigned MASK_W   = 64;
    localparam int unsigned COUNT_W  = 8;
    localparam int unsigned MIN_W    = 8;
    localparam int unsigned IDX_W    = 3;
    localparam int unsigned OPC_W    = 8;

    localparam logic [OPC_W-1:0] OPC_NARROW = 8'h30;
    localparam logic [OPC_W-1:0] OPC_WIDE   = 8'h31;
    localparam logic [1:0]       MOD_REG    = 2'b11;

    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_32 = 2'd2,
        WID_64 = 2'd3
    } width_e;

    typedef struct packed {
        logic             legal;
        width_e           width;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] src;
    } decode_t;

endpackage

// File: rtl/mask_rshift_decode.sv
`timescale 1ns/1ps
// Module: mask_rshift_decode
// Decodes the opcode byte, width bit and ModRM byte into an operand
// width, a legality flag and the two register indices.
// Assumes: purely combinational; legality ignores in_valid.
module mask_rshift_decode
    import mask_rshift_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic             w_bit,
    input  logic [7:0]       modrm,
    output decode_t          dec
);

    logic opc_ok;
    logic mod_ok;

    // Purpose: classify the encoding and pick the width.
    always_comb begin
        opc_ok    = (opcode == OPC_NARROW) || (opcode == OPC_WIDE);
        mod_ok    = (modrm[7:6] == MOD_REG);
        dec.legal = opc_ok && mod_ok;
        dec.width = width_e'({opcode[0], w_bit});
        dec.dst   = modrm[5:3];
        dec.src   = modrm[2:0];
    end

endmodule

// File: rtl/mask_rshift_lanes.sv
`timescale 1ns/1ps
// Module: mask_rshift_lanes
// Builds one shift lane per supported width (MIN_W doubling up to DATA_W),
// each masking the source, range-checking the count and shifting; then
// selects the lane named by the width index.
// Assumes: DATA_W == LANE_MIN << (N_LANES-1); count unsigned.
module mask_rshift_lanes #(
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned LANE_MIN = 8,
    parameter int unsigned N_LANES  = 4,
    localparam int unsigned SEL_W   = (N_LANES > 1) ? $clog2(N_LANES) : 1
) (
    input  logic [DATA_W-1:0] src,
    input  logic [CNT_W-1:0]  count,
    input  logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] lane_res [N_LANES];

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int unsigned LW = LANE_MIN << g;
        localparam logic [DATA_W-1:0] LMASK = {DATA_W{1'b1}} >> (DATA_W - LW);
        localparam logic [CNT_W:0] LMAX = (CNT_W+1)'(LW - 1);

        // Purpose: zero out-of-range counts, else shift the masked source.
        always_comb begin
            if ({1'b0, count} > LMAX) begin
                lane_res[g] = '0;
            end else begin
                lane_res[g] = (src & LMASK) >> count;
            end
        end
    end

    // Purpose: pick the lane for the decoded width.
    always_comb begin
        result = '0;
        for (int i = 0; i < N_LANES; i++) begin
            if (sel == SEL_W'(i)) begin
                result = lane_res[i];
            end
        end
    end

endmodule

// File: rtl/mask_rshift_unit.sv
`timescale 1ns/1ps
// Module: mask_rshift_unit (top)
// Decodes an immediate mask right shift, computes it at the selected
// width and registers result, indices, valid and illegal pulse.
// Assumes: synchronous active-low reset; one input per cycle, no stall.
module mask_rshift_unit
    import mask_rshift_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [OPC_W-1:0]   opcode,
    input  logic               w_bit,
    input  logic [7:0]         modrm,
    input  logic [COUNT_W-1:0] imm_count,
    input  logic [MASK_W-1:0]  src_mask,
    output logic               out_valid,
    output logic [MASK_W-1:0]  dst_mask,
    output logic [IDX_W-1:0]   dst_idx,
    output logic [IDX_W-1:0]   src_idx,
    output logic               bad_enc
);

    localparam int unsigned N_LANES = $clog2(MASK_W / MIN_W) + 1;

    decode_t           dec;
    logic [MASK_W-1:0] shifted;
    logic              accept;
    logic              reject;

    mask_rshift_decode i_decode (
        .opcode (opcode),
        .w_bit  (w_bit),
        .modrm  (modrm),
        .dec    (dec)
    );

    mask_rshift_lanes #(
        .DATA_W   (MASK_W),
        .CNT_W    (COUNT_W),
        .LANE_MIN (MIN_W),
        .N_LANES  (N_LANES)
    ) i_lanes (
        .src    (src_mask),
        .count  (imm_count),
        .sel    (dec.width),
        .result (shifted)
    );

    // Purpose: split the strobe into accepted and rejected inputs.
    always_comb begin
        accept = in_valid && dec.legal;
        reject = in_valid && !dec.legal;
    end

    // Purpose: one-cycle result register; destination holds unless accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            bad_enc   <= 1'b0;
            dst_mask  <= '0;
            dst_idx   <= '0;
            src_idx   <= '0;
        end else begin
            out_valid <= accept;
            bad_enc   <= reject;
            if (accept) begin
                dst_mask <= shifted;
                dst_idx  <= dec.dst;
                src_idx  <= dec.src;
            end
        end
    end

endmodule

// File: rtl/mask_rshift_unit_chk.sv
`timescale 1ns/1ps
// Module: mask_rshift_unit_chk
// Property checker bound to mask_rshift_unit; observes ports only.
module mask_rshift_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [7:0]  opcode,
    input logic        w_bit,
    input logic [7:0]  modrm,
    input logic [7:0]  imm_count,
    input logic        out_valid,
    input logic [63:0] dst_mask,
    input logic [2:0]  dst_idx,
    input logic        bad_enc
);

    logic opc_in_set;
    logic legal_in;

    // Purpose: independent view of an accepted encoding.
    always_comb begin
        opc_in_set = (opcode == 8'h30) || (opcode == 8'h31);
        legal_in   = in_valid && opc_in_set && (modrm[7:6] == 2'b11);
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !bad_enc && dst_mask == 64'd0));

    assert_big_count_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_in && imm_count > 8'd63) |=> (dst_mask == 64'd0));

    assert_byte_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_in && opcode == 8'h30 && !w_bit) |=> (dst_mask[63:8] == 56'd0));

    assert_bad_mod_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && modrm[7:6] != 2'b11) |=> (bad_enc && !out_valid && $stable(dst_mask)));

    assert_bad_opcode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !opc_in_set) |=> (bad_enc && !out_valid && $stable(dst_mask)));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !bad_enc && $stable(dst_mask)));

    assert_accept_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        legal_in |=> (out_valid && !bad_enc));

    assert_dst_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
        legal_in |=> (dst_idx == $past(modrm[5:3])));

endmodule

bind mask_rshift_unit mask_rshift_unit_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .w_bit     (w_bit),
    .modrm     (modrm),
    .imm_count (imm_count),
    .out_valid (out_valid),
    .dst_mask  (dst_mask),
    .dst_idx   (dst_idx),
    .bad_enc   (bad_enc)
);

// File: tb/test_mask_rshift_unit.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random vectors, compared against
// a behavioural model written from the requirements.
module test_mask_rshift_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic        w_bit = 1'b0;
    logic [7:0]  modrm = 8'h00;
    logic [7:0]  imm_count = 8'h00;
    logic [63:0] src_mask = 64'd0;
    logic        out_valid;
    logic [63:0] dst_mask;
    logic [2:0]  dst_idx;
    logic [2:0]  src_idx;
    logic        bad_enc;

    int n_vec = 0;
    int n_bad = 0;
    logic [63:0] exp_dst = 64'd0;
    logic [2:0]  exp_didx = 3'd0;
    logic [2:0]  exp_sidx = 3'd0;

    always #4 clk = ~clk;

    mask_rshift_unit i_mask_rshift_unit (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .opcode (opcode),
        .w_bit (w_bit), .modrm (modrm), .imm_count (imm_count),
        .src_mask (src_mask), .out_valid (out_valid), .dst_mask (dst_mask),
        .dst_idx (dst_idx), .src_idx (src_idx), .bad_enc (bad_enc)
    );

    function automatic logic [63:0] model(logic [7:0] opc, logic w,
                                          logic [7:0] cnt, logic [63:0] src);
        int unsigned wd;
        logic [63:0] m;
        wd = 8 << {opc[0], w};
        if (int'(cnt) > int'(wd) - 1) return 64'd0;
        m = (wd == 64) ? {64{1'b1}} : ((64'd1 << wd) - 64'd1);
        return (src & m) >> cnt;
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drives at a falling edge, checks one full cycle later at the next falling edge.
    task automatic step(string req, logic v, logic [7:0] opc, logic w,
                        logic [7:0] mr, logic [7:0] cnt, logic [63:0] src);
        logic legal;
        in_valid = v; opcode = opc; w_bit = w; modrm = mr;
        imm_count = cnt; src_mask = src;
        legal = (opc == 8'h30 || opc == 8'h31) && (mr[7:6] == 2'b11);
        if (v && legal) begin
            exp_dst  = model(opc, w, cnt, src);
            exp_didx = mr[5:3];
            exp_sidx = mr[2:0];
        end
        @(negedge clk);
        chk(req, "out_valid", {63'd0, out_valid}, {63'd0, v && legal});
        chk(req, "bad_enc", {63'd0, bad_enc}, {63'd0, v && !legal});
        chk(req, "dst_mask", dst_mask, exp_dst);
        chk("R9", "idx", {58'd0, dst_idx, src_idx}, {58'd0, exp_didx, exp_sidx});
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "out_valid", {63'd0, out_valid}, 64'd0);
        chk("R1", "bad_enc", {63'd0, bad_enc}, 64'd0);
        chk("R1", "dst_mask", dst_mask, 64'd0);
        rst_n = 1'b1;

        // R5: count zero passes masked source, each width (R2 width decode)
        for (int k = 0; k < 4; k++) begin
            step("R5", 1'b1, k[1] ? 8'h31 : 8'h30, k[0], 8'hC0 | 8'(k * 9),
                 8'd0, 64'hF0E1_D2C3_B4A5_9687);
        end
        // R2/R3: width minus one, width, and 255 per width
        for (int k = 0; k < 4; k++) begin
            int unsigned wd;
            wd = 8 << k;
            step("R2", 1'b1, k[1] ? 8'h31 : 8'h30, k[0], 8'hD5, 8'(wd - 1), 64'hFFFF_FFFF_FFFF_FFFF);
            step("R3", 1'b1, k[1] ? 8'h31 : 8'h30, k[0], 8'hEA, 8'(wd), 64'hFFFF_FFFF_FFFF_FFFF);
            step("R3", 1'b1, k[1] ? 8'h31 : 8'h30, k[0], 8'hFF, 8'd255, 64'hFFFF_FFFF_FFFF_FFFF);
        end
        // R4: narrow width, source upper bits set
        step("R4", 1'b1, 8'h30, 1'b0, 8'hC3, 8'd1, 64'hFFFF_FFFF_FFFF_FF80);
        step("R4", 1'b1, 8'h30, 1'b1, 8'hCB, 8'd4, 64'hAAAA_AAAA_AAAA_1234);
        // R6: bad mod after a legal result must hold it
        step("R6", 1'b1, 8'h31, 1'b1, 8'hC9, 8'd3, 64'h8000_0000_0000_0008);
        step("R6", 1'b1, 8'h31, 1'b1, 8'h89, 8'd0, 64'h1234_5678_9ABC_DEF0);
        step("R6", 1'b1, 8'h30, 1'b0, 8'h01, 8'd0, 64'h0000_0000_0000_00FF);
        // R7: other opcodes
        step("R7", 1'b1, 8'h32, 1'b0, 8'hC0, 8'd0, 64'hFFFF_0000_FFFF_0000);
        step("R7", 1'b1, 8'hB0, 1'b1, 8'hFF, 8'd2, 64'h0000_FFFF_0000_FFFF);
        // R8: idle cycles keep outputs and pulse nothing
        step("R8", 1'b0, 8'h30, 1'b0, 8'hC0, 8'd0, 64'hDEAD_BEEF_DEAD_BEEF);
        step("R8", 1'b1, 8'h30, 1'b1, 8'hF1, 8'd2, 64'h0000_0000_0000_FFFC);
        step("R8", 1'b0, 8'h31, 1'b1, 8'hC0, 8'd0, 64'hFFFF_FFFF_FFFF_FFFF);

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] opc;
            logic [7:0] mr;
            logic [7:0] cnt;
            logic [63:0] src;
            logic v;
            string tag;
            v   = ($urandom % 100) < 85;
            opc = (($urandom % 10) == 0) ? 8'($urandom) : (($urandom % 2) ? 8'h31 : 8'h30);
            mr  = 8'($urandom);
            if (($urandom % 8) != 0) mr[7:6] = 2'b11;
            cnt = (($urandom % 4) == 0) ? 8'($urandom) : 8'($urandom % 64);
            src = {$urandom, $urandom};
            if (!v) tag = "R8";
            else if (mr[7:6] != 2'b11) tag = "R6";
            else if (opc != 8'h30 && opc != 8'h31) tag = "R7";
            else if (cnt > 8'd7) tag = "R3";
            else tag = "R2";
            step(tag, v, opc, ($urandom % 2) == 1, mr, cnt, src);
        end

        // R1: reset in mid-run clears outputs
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "dst_mask after reset", dst_mask, 64'd0);
        chk("R1", "idx after reset", {58'd0, dst_idx, src_idx}, 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule